// File: doc/BRIEF.md
# Reloading Down-Counter Interval Timer

This block is a programmable interval timer. An 8-bit down-counter counts one step for each prescaled tick while the timer runs. When it is at zero and a tick arrives, it does not wrap. It takes the reload value and raises an underflow event instead. The timer therefore fires once every reload+1 enabled ticks.

Every underflow drives four outputs:
- an interrupt flag that stays set until software clears it,
- a one-cycle strobe for a DMA engine,
- a one-cycle pulse meant for an external pin,
- a clock at half the underflow rate, made by a flip-flop that toggles on each event.

Software writes the reload value through a simple write strobe. It starts and stops the timer with a run level. Arbitration of the interrupt and DMA requests and pin routing happen outside the block.

Top module: `ivt_timer`

## Requirements
- R1: During and right after reset, `irq_o`, `dma_req_o`, `pin_o` and `half_clk_o` are low, and the counter and reload value are zero.
- R2: While `run_i` is high, the counter decreases by one on each clock edge with `tick_i` high. With `tick_i` low or `run_i` low, no count happens and no event is raised.
- R3: When `run_i` and `tick_i` are high and the counter is zero, the counter takes the reload value and an underflow event occurs. Events repeat every reload+1 ticks, and a reload of 0 gives an event on every tick.
- R4: `dma_req_o` and `pin_o` are high for exactly the one cycle after each underflow edge, and low otherwise.
- R5: `irq_o` is set in the cycle after an underflow and stays set until a cycle with `irq_clr_i` high clears it. If an underflow and a clear fall on the same edge, the flag stays set.
- R6: `half_clk_o` inverts in the cycle after each underflow and holds its level at all other times, including while the timer is stopped.
- R7: A write (`preset_we_i` high) while `run_i` is low stores `preset_i` as the reload value and also loads it into the counter.
- R8: A write while `run_i` is high updates only the reload value, and the count in progress continues. The new value is used at the next underflow, including an underflow on the same edge as the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Timer runs while high |
| tick_i | input | 1 | Prescaled count enable, one edge per count |
| preset_we_i | input | 1 | Write strobe for the reload value |
| preset_i | input | 8 | Reload value to write |
| irq_clr_i | input | 1 | Clears the interrupt flag (write-one-to-clear) |
| irq_o | output | 1 | Sticky interrupt request |
| dma_req_o | output | 1 | One-cycle DMA trigger per underflow |
| pin_o | output | 1 | One-cycle underflow pulse for an external pin |
| half_clk_o | output | 1 | Underflow rate divided by two |

## Verification
The event period is measured with ticks on every cycle and with ticks on every other cycle. The first run fixes the reload+1 relation, and the second shows that only ticked edges count. A reload of zero separates a correct reload from a wrap to 255, since only the correct design fires on every tick. Writes while running versus stopped separate a reload-only update from a counter load, and a run with the timer stopped shows that nothing moves without run. A long random stream mixes ticks, writes, stop phases and interrupt clears, which also hits clears that fall on an underflow edge.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  parameter int unsigned IVT_CNT_W = 8;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_DEC    = 2'd1,
    ACT_RELOAD = 2'd2,
    ACT_LOAD   = 2'd3
  } ivt_act_e;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
#(
  parameter int unsigned W = IVT_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic         uf_o
);
  logic [W-1:0] cnt_q, rld_q, rld_nxt;
  logic         at_zero;
  ivt_act_e     act;

  // Selects what the counter does on this edge
  function automatic ivt_act_e pick_act(input logic r, input logic t,
                                        input logic w, input logic z);
    if (r && t) return z ? ACT_RELOAD : ACT_DEC;
    if (!r && w) return ACT_LOAD;
    return ACT_HOLD;
  endfunction

  assign at_zero = (cnt_q == '0);
  assign act     = pick_act(run, tick, we, at_zero);
  assign rld_nxt = we ? wdata : rld_q;
  assign uf_o    = (act == ACT_RELOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      rld_q <= rld_nxt;
      unique case (act)
        ACT_DEC:    cnt_q <= cnt_q - 1'b1;
        ACT_RELOAD: cnt_q <= rld_nxt;
        ACT_LOAD:   cnt_q <= wdata;
        default:    cnt_q <= cnt_q;
      endcase
    end
  end

  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !we) |=> $stable(cnt_q));
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uf_o |=> cnt_q == rld_q);
  p_stop_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && we) |=> (cnt_q == $past(wdata)) && (rld_q == $past(wdata)));
  p_run_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && we && !tick) |=> $stable(cnt_q) && (rld_q == $past(wdata)));
endmodule

// File: rtl/ivt_events.sv
module ivt_events (
  input  logic clk,
  input  logic rst_n,
  input  logic uf,
  input  logic irq_clr,
  output logic irq_o,
  output logic dma_o,
  output logic pin_o,
  output logic half_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      dma_o  <= 1'b0;
      pin_o  <= 1'b0;
      half_o <= 1'b0;
    end else begin
      dma_o  <= uf;
      pin_o  <= uf;
      half_o <= half_o ^ uf;
      if (uf)           irq_o <= 1'b1;
      else if (irq_clr) irq_o <= 1'b0;
    end
  end

  p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> dma_o && pin_o);
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !uf |=> !dma_o && !pin_o);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr) |=> irq_o);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> irq_o);
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> half_o != $past(half_o));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !uf |=> $stable(half_o));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned W = IVT_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         preset_we_i,
  input  logic [W-1:0] preset_i,
  input  logic         irq_clr_i,
  output logic         irq_o,
  output logic         dma_req_o,
  output logic         pin_o,
  output logic         half_clk_o
);
  logic underflow;

  ivt_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_i),
    .tick  (tick_i),
    .we    (preset_we_i),
    .wdata (preset_i),
    .uf_o  (underflow)
  );

  ivt_events u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .uf      (underflow),
    .irq_clr (irq_clr_i),
    .irq_o   (irq_o),
    .dma_o   (dma_req_o),
    .pin_o   (pin_o),
    .half_o  (half_clk_o)
  );

  p_no_event_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i || !tick_i) |=> !dma_req_o);
endmodule

// File: tb/ivt_timer_tb_top.sv
`timescale 1ns/1ps
module ivt_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0, tick_i = 1'b0, preset_we_i = 1'b0, irq_clr_i = 1'b0;
  logic [7:0] preset_i = '0;
  logic irq_o, dma_req_o, pin_o, half_clk_o;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_cnt = '0, m_rld = '0;
  logic m_irq = 0, m_dma = 0, m_pin = 0, m_half = 0;

  always #5 clk = ~clk;

  ivt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .tick_i(tick_i),
    .preset_we_i(preset_we_i), .preset_i(preset_i), .irq_clr_i(irq_clr_i),
    .irq_o(irq_o), .dma_req_o(dma_req_o), .pin_o(pin_o), .half_clk_o(half_clk_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: does this edge raise an event (R2, R3)
  function automatic bit fires(bit r, bit t, logic [7:0] c);
    return r && t && (c == 8'd0);
  endfunction

  // Reference: counter value after an edge (R2, R3, R7, R8)
  function automatic logic [7:0] count_after(bit r, bit t, bit w, logic [7:0] d,
                                             logic [7:0] c, logic [7:0] rl);
    logic [7:0] eff = w ? d : rl;
    if (r && t) return (c == 0) ? eff : c - 8'd1;
    if (!r && w) return d;
    return c;
  endfunction

  task automatic step(input bit r, input bit t, input bit w, input logic [7:0] d, input bit c);
    bit ev;
    run_i = r; tick_i = t; preset_we_i = w; preset_i = d; irq_clr_i = c;
    @(posedge clk);
    ev = fires(r, t, m_cnt);
    m_cnt = count_after(r, t, w, d, m_cnt, m_rld);
    if (w) m_rld = d;
    m_dma = ev; m_pin = ev;
    m_irq = ev ? 1'b1 : (c ? 1'b0 : m_irq);
    m_half = m_half ^ ev;
    @(negedge clk);
    chk("R4 dma_req_o", dma_req_o, m_dma);
    chk("R4 pin_o", pin_o, m_pin);
    chk("R5 irq_o", irq_o, m_irq);
    chk("R6 half_clk_o", half_clk_o, m_half);
  endtask

  // Steps with run high until the next event; returns the step count
  task automatic next_gap(input bit half_rate, output int g);
    g = 0;
    for (int k = 0; k < 600; k++) begin
      step(1'b1, half_rate ? k[0] : 1'b1, 1'b0, 8'd0, 1'b0);
      g++;
      if (dma_req_o) break;
    end
  endtask

  initial begin
    int g;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 irq_o", irq_o, 0);
    chk("R1 dma_req_o", dma_req_o, 0);
    chk("R1 pin_o", pin_o, 0);
    chk("R1 half_clk_o", half_clk_o, 0);
    rst_n = 1'b1;
    // R1: reset left reload 0, so a running timer fires on every tick
    step(1'b1, 1'b1, 1'b0, 8'd0, 1'b0);
    chk("R1 first tick fires with zero reload", dma_req_o, 1);
    step(1'b0, 1'b0, 1'b0, 8'd0, 1'b0);
    // R7: stopped write loads counter; R2: stopped ticks do nothing
    step(1'b0, 1'b0, 1'b1, 8'd3, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, 8'd0, 1'b0);
    next_gap(1'b0, g);
    chk("R7 first period after stopped load", g, 4);
    next_gap(1'b0, g);
    chk("R3 period reload+1", g, 4);
    next_gap(1'b1, g);
    chk("R2 period counts only ticks", g, 8);
    // R8: running write changes reload only
    step(1'b1, 1'b1, 1'b1, 8'd1, 1'b0);
    next_gap(1'b0, g);
    chk("R8 count in progress unchanged", g + 1, 4);
    next_gap(1'b0, g);
    chk("R8 new reload used", g, 2);
    // R3: reload 0 fires every tick
    step(1'b1, 1'b1, 1'b1, 8'd0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 8'd0, 1'b0);
    next_gap(1'b0, g);
    chk("R3 zero reload period", g, 1);
    // R5: clear on an event edge keeps flag; plain clear drops it
    step(1'b1, 1'b1, 1'b0, 8'd0, 1'b1);
    chk("R5 set wins over clear", irq_o, 1);
    step(1'b0, 1'b0, 1'b0, 8'd0, 1'b1);
    chk("R5 clear", irq_o, 0);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      bit r = ($urandom_range(0, 9) != 0);
      bit t = ($urandom_range(0, 1) == 1);
      bit w = ($urandom_range(0, 19) == 0);
      logic [7:0] d = 8'($urandom_range(0, 7));
      bit c = ($urandom_range(0, 7) == 0);
      step(r, t, w, d, c);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule